// File: doc/BRIEF.md
# Field-Masked BCD Alarm Comparator

This block watches a calendar that is kept elsewhere. Each time the calendar advances by one second it compares the current time against six stored alarm values: second, minute, hour, day of month, month and a three-digit year. All values are in BCD. Each field has its own enable bit, and a global enable gates the whole comparison. The alarm fires when any single enabled field equals its stored value, so the fields combine by OR and not by AND.

A match sets a sticky pending flag, and a level interrupt line follows that flag. Software clears the flag by writing one to its bit. A simple register port loads the alarm fields and the control word and reads them back. It has one write channel and one combinational read channel. Every stored alarm field keeps only as many low bits as its BCD range needs.

The calendar counter and the bus decoding are not part of this block. The block's time inputs are plain BCD buses, and a one-cycle strobe marks each new second.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset, every register reads zero and `alarm_irq` is low. Register addresses are: 0 control, 1 pending, 2 second, 3 minute, 4 hour, 5 day of month, 6 month, 7 year.
- R2: A write keeps only the low bits of `wr_data`: 7 for second and minute, 6 for hour and day, 5 for month and 12 for year. All higher read bits are zero.
- R3: Control bits 0 to 5 enable the comparison of second, minute, hour, day, month and year, in that order. A field whose bit is clear never causes a match.
- R4: Control bit 6 is the global enable. While it is clear, no strobe sets the pending flag.
- R5: The comparison takes place only in a cycle where `sec_tick` is high. Its result is registered at the clock edge that ends that cycle. A matching time that is present without a strobe has no effect.
- R6: The alarm fires if at least one enabled field matches, even when the other enabled fields do not match.
- R7: The year alarm is compared on all 12 bits. Bits 11:8 hold the hundreds digit and bits 7:0 hold the tens and units, so a year that differs only in the hundreds digit does not match.
- R8: The pending flag is sticky and reads back at bit 1 of address 1. `alarm_irq` equals that flag.
- R9: Writing 1 to bit 1 of address 1 clears the flag. Writing 0 there, or setting only bit 0, leaves the flag unchanged. If a set and a clear fall in the same cycle, the set wins.
- R10: Control reads back bits 6:0 as written, and its higher bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sec_tick | input | 1 | One-cycle strobe at each one-second advance |
| cur_sec | input | 8 | Current second, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_year | input | 12 | Current year, three BCD digits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| alarm_irq | output | 1 | Level alarm interrupt, equal to the pending flag |

## Verification
The bench builds the block with the default DATA_W of 16. This width lets it drive bits 12 to 15 on every write and confirm that each field, including the 12-bit year, drops them. A behavioural model of the registers and the pending flag is compared with `alarm_irq` and the read data on every clock. Directed sequences cover the global gate, masked fields, OR matching, the hundreds digit of the year, a match held without a strobe, and a set that coincides with a clear.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NFLD     = 6;
  localparam int FLD_W    = 12;
  localparam int CTRL_W   = 7;
  localparam int GLB_BIT  = 6;
  localparam int PEND_BIT = 1;
  localparam int ADDR_W   = 3;

  typedef logic [FLD_W-1:0] fld_t;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_PEND = 3'd1,
    A_SEC  = 3'd2,
    A_MIN  = 3'd3,
    A_HOUR = 3'd4,
    A_DAY  = 3'd5,
    A_MON  = 3'd6,
    A_YEAR = 3'd7
  } reg_addr_e;

  // Stored width of each alarm field, index 0 = second .. 5 = year
  function automatic int fld_w(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
  import alarm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic                         pend,
  output logic [DATA_W-1:0]            rd_data,
  output logic [CTRL_W-1:0]            ctrl_q,
  output logic [NFLD-1:0][FLD_W-1:0]   alm_q
);
  localparam int FIRST_FLD = int'(A_SEC);

  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;

  assign ctrl_en = wr_en && (wr_addr == A_CTRL);
  always_comb ctrl_d = ctrl_en ? wr_data[CTRL_W-1:0] : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    localparam int   W    = fld_w(g);
    localparam fld_t MASK = fld_t'((1 << W) - 1);
    logic we;
    fld_t d;
    assign we = wr_en && (wr_addr == ADDR_W'(g + FIRST_FLD));
    always_comb d = we ? (wr_data[FLD_W-1:0] & MASK) : alm_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_q[g] <= '0;
      else        alm_q[g] <= d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
      A_PEND:  rd_data[PEND_BIT]   = pend;
      default: rd_data[FLD_W-1:0]  = alm_q[int'(rd_addr) - FIRST_FLD];
    endcase
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
(
  input  logic                        tick,
  input  logic [CTRL_W-1:0]           ctrl,
  input  logic [NFLD-1:0][FLD_W-1:0]  alm,
  input  logic [NFLD-1:0][FLD_W-1:0]  cur,
  output logic                        hit
);
  logic [NFLD-1:0] fld_hit;

  for (genvar g = 0; g < NFLD; g++) begin : g_cmp
    assign fld_hit[g] = ctrl[g] && (cur[g] == alm[g]);
  end

  assign hit = tick && ctrl[GLB_BIT] && (|fld_hit);
endmodule

// File: rtl/alarm_pending.sv
module alarm_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pend
);
  logic pend_d;
  logic pend_en;

  assign pend_en = set || clr;
  always_comb pend_d = set ? 1'b1 : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (pend_en) pend <= pend_d;
  end
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import alarm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [7:0]        cur_sec,
  input  logic [7:0]        cur_min,
  input  logic [7:0]        cur_hour,
  input  logic [7:0]        cur_mday,
  input  logic [7:0]        cur_mon,
  input  logic [11:0]       cur_year,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_irq
);
  logic rst_meta;
  logic rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [CTRL_W-1:0]          ctrl_q;
  logic [NFLD-1:0][FLD_W-1:0] alm_q;
  logic [NFLD-1:0][FLD_W-1:0] cur;
  logic                       hit;
  logic                       clr;
  logic                       pend;

  assign cur[0] = {4'h0, cur_sec};
  assign cur[1] = {4'h0, cur_min};
  assign cur[2] = {4'h0, cur_hour};
  assign cur[3] = {4'h0, cur_mday};
  assign cur[4] = {4'h0, cur_mon};
  assign cur[5] = cur_year;

  assign clr = wr_en && (wr_addr == A_PEND) && wr_data[PEND_BIT];

  alarm_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .pend    (pend),
    .rd_data (rd_data),
    .ctrl_q  (ctrl_q),
    .alm_q   (alm_q)
  );

  alarm_match u_match (
    .tick (sec_tick),
    .ctrl (ctrl_q),
    .alm  (alm_q),
    .cur  (cur),
    .hit  (hit)
  );

  alarm_pending u_pend (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set   (hit),
    .clr   (clr),
    .pend  (pend)
  );

  assign alarm_irq = pend;
endmodule

// File: rtl/bcd_alarm_cmp_chk.sv
module bcd_alarm_cmp_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              sec_tick,
  input logic              wr_en,
  input logic [2:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [2:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic [6:0]        ctrl_q,
  input logic              alarm_irq
);
  logic clr_req;
  assign clr_req = wr_en && (wr_addr == 3'd1) && wr_data[1];

  p_rise_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(alarm_irq) |-> $past(sec_tick));

  p_rise_needs_global_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(alarm_irq) |-> $past(ctrl_q[6]));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (alarm_irq && !clr_req) |=> alarm_irq);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (clr_req && !sec_tick) |=> !alarm_irq);

  p_pend_read_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_addr == 3'd1) |-> (rd_data[1] == alarm_irq));

  p_sec_trunc_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_addr == 3'd2) |-> (rd_data[DATA_W-1:7] == '0));
endmodule

bind bcd_alarm_cmp bcd_alarm_cmp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .sec_tick   (sec_tick),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .ctrl_q     (ctrl_q),
  .alarm_irq  (alarm_irq)
);

// File: tb/bcd_alarm_cmp_tb.sv
module bcd_alarm_cmp_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sec_tick = 1'b0;
  logic [7:0]        cur_sec = '0, cur_min = '0, cur_hour = '0, cur_mday = '0, cur_mon = '0;
  logic [11:0]       cur_year = '0;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [2:0]        rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  logic              alarm_irq;

  int tests = 0;
  int fails = 0;
  bit chk_on = 1'b0;

  // behavioural model state
  int m_ctrl = 0;
  int m_pend = 0;
  int m_alm[6] = '{0, 0, 0, 0, 0, 0};

  always #(CLK_P/2) clk = ~clk;

  bcd_alarm_cmp #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_mon(cur_mon), .cur_year(cur_year),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_rd(input int a);
    case (a)
      0:       return m_ctrl;
      1:       return m_pend << 1;
      default: return m_alm[a-2];
    endcase
  endfunction

  // model: compare with pre-write values, then apply writes
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pend = 0;
      foreach (m_alm[i]) m_alm[i] = 0;
    end else begin
      int cur[6];
      bit any;
      bit clr;
      cur[0] = cur_sec; cur[1] = cur_min; cur[2] = cur_hour;
      cur[3] = cur_mday; cur[4] = cur_mon; cur[5] = cur_year;
      any = 1'b0;
      for (int i = 0; i < 6; i++)
        if (((m_ctrl >> i) & 1) == 1 && cur[i] == m_alm[i]) any = 1'b1;
      clr = wr_en && wr_addr == 3'd1 && wr_data[1];
      if (sec_tick && ((m_ctrl >> 6) & 1) == 1 && any) m_pend = 1;
      else if (clr) m_pend = 0;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_ctrl = int'(wr_data) % 128;
          3'd1: ;
          3'd2, 3'd3: m_alm[wr_addr-2] = int'(wr_data) % 128;
          3'd4, 3'd5: m_alm[wr_addr-2] = int'(wr_data) % 64;
          3'd6: m_alm[4] = int'(wr_data) % 32;
          default: m_alm[5] = int'(wr_data) % 4096;
        endcase
      end
    end
  end

  // per-clock comparison against the model
  initial forever begin
    @(negedge clk);
    #1;
    if (chk_on) begin
      chk("R8 irq vs model", int'(alarm_irq), m_pend);
      chk("R2 read vs model", int'(rd_data), model_rd(int'(rd_addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_time(input int s, input int mi, input int h,
                          input int d, input int mo, input int y);
    cur_sec = 8'(s); cur_min = 8'(mi); cur_hour = 8'(h);
    cur_mday = 8'(d); cur_mon = 8'(mo); cur_year = 12'(y);
  endtask

  task automatic tick_at(input int s, input int mi, input int h,
                         input int d, input int mo, input int y);
    @(negedge clk);
    set_time(s, mi, h, d, mo, y);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    rd_addr = 3'(a);
    #2 chk(tag, int'(rd_data), exp);
  endtask

  task automatic irq_chk(input int exp, input string tag);
    #2 chk(tag, int'(alarm_irq), exp);
  endtask

  initial begin
    #(CLK_P * 50000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) rd_chk(a, 0, "R1 reset read");
    irq_chk(0, "R1 reset irq");

    // R2 / R10: truncation on write
    wr(2, 'hFFFF); rd_chk(2, 'h7F,  "R2 second width");
    wr(3, 'hFFFF); rd_chk(3, 'h7F,  "R2 minute width");
    wr(4, 'hFFFF); rd_chk(4, 'h3F,  "R2 hour width");
    wr(5, 'hFFFF); rd_chk(5, 'h3F,  "R2 day width");
    wr(6, 'hFFFF); rd_chk(6, 'h1F,  "R2 month width");
    wr(7, 'hFFFF); rd_chk(7, 'hFFF, "R2 year width");
    wr(0, 'hFFFF); rd_chk(0, 'h7F,  "R10 control width");
    wr(0, 0);
    for (int a = 2; a < 8; a++) wr(a, 0);

    // R4: global enable clear blocks the alarm
    wr(2, 'h30); wr(0, 'h01);
    tick_at('h30, 0, 0, 0, 0, 0); irq_chk(0, "R4 global off");

    // R5: matching time without a strobe, then with one
    wr(0, 'h41);
    @(negedge clk); set_time('h30, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    irq_chk(0, "R5 no strobe");
    tick_at('h29, 0, 0, 0, 0, 0); irq_chk(0, "R3 second mismatch");
    tick_at('h30, 0, 0, 0, 0, 0); irq_chk(1, "R5 second match");
    rd_chk(1, 2, "R8 pending bit1");

    // R8 / R9: sticky flag and write-one-to-clear
    tick_at('h31, 0, 0, 0, 0, 0); irq_chk(1, "R8 sticky");
    wr(1, 0);   irq_chk(1, "R9 write 0 keeps");
    wr(1, 1);   irq_chk(1, "R9 bit0 keeps");
    wr(1, 2);   irq_chk(0, "R9 clear");

    // R3: disabled field matching has no effect
    wr(3, 'h15); wr(0, 'h42);
    tick_at('h30, 'h16, 0, 0, 0, 0); irq_chk(0, "R3 masked second");
    tick_at('h30, 'h15, 0, 0, 0, 0); irq_chk(1, "R3 minute match");
    wr(1, 2);

    // R6: OR of enabled fields, only the month matches
    wr(2, 'h01); wr(3, 'h02); wr(4, 'h03); wr(5, 'h04); wr(6, 'h12); wr(7, 'h199);
    wr(0, 'h7F);
    tick_at('h59, 'h59, 'h23, 'h28, 'h11, 'h024); irq_chk(0, "R6 none match");
    tick_at('h59, 'h59, 'h23, 'h28, 'h12, 'h024); irq_chk(1, "R6 month only");
    wr(1, 2); irq_chk(0, "R9 clear after R6");

    // R7: three-digit year
    wr(7, 'h123); wr(0, 'h60);
    tick_at(0, 0, 0, 0, 0, 'h023); irq_chk(0, "R7 hundreds zero");
    tick_at(0, 0, 0, 0, 0, 'h223); irq_chk(0, "R7 hundreds differ");
    tick_at(0, 0, 0, 0, 0, 'h123); irq_chk(1, "R7 year match");

    // R9: set and clear in the same cycle, set wins
    @(negedge clk);
    set_time(0, 0, 0, 0, 0, 'h123);
    sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = DATA_W'(2);
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    irq_chk(1, "R9 set beats clear");
    wr(1, 2); irq_chk(0, "R9 final clear");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule